// File: doc/BRIEF.md
# Two-Deep Controller Command Queue

This block sits between a host bus and a bus-protocol sequencer. The host writes 8-bit command bytes with a single write strobe. The block keeps up to two of them in arrival order and shows the oldest one on a readback port. Software commonly writes an operation and then writes it again with the DMA request bit set, and two entries are enough for that pattern.

Each command is checked against the controller's current role only when it reaches the head of the queue. The mode-group bits of the byte name the role the command belongs to. A command that fits the role is offered to the sequencer on a valid/ready handshake. The handshake carries the 7-bit operation and the DMA flag. A command that does not fit the role is removed from the queue and raises a one-cycle illegal-command pulse. A FIFO flush holds back the next command for a fixed number of cycles. A reset-chip write takes effect at once and empties the queue.

Top module: `cmdq_top`

## Requirements
- R1: After `rst_n` is released, the queue is empty. `iss_valid`, `illegal_o` and `ovf_flag` are 0, and `head_data` is 0x00.
- R2: Entries issue in arrival order, one per cycle with `iss_valid` and `iss_ready` both high. `iss_op` is bits 6:0 of the byte and `iss_dma` is bit 7.
- R3: A write while two entries are held is dropped, even when the head leaves in the same cycle, and it sets `ovf_flag`. `ovf_flag` stays set until reset or a reset-chip write.
- R4: Legality is decided by bits 6:4 of the byte, with roles encoded on `role_i` as 0 disconnected, 1 initiator, 2 target and 3 none.
  - 100 is legal only in role 0.
  - 010 is legal only in role 2.
  - 001 is legal only in role 1.
  - 000 is legal in every role, except operation 0x04, which is legal only in role 2.
  - Any other pattern is never legal.
- R5: An illegal head entry is removed in the cycle it is seen, with `iss_valid` low. `illegal_o` is high for exactly that cycle.
- R6: After a handshake on operation 0x01, `iss_valid` and `illegal_o` stay low for FLUSH_CYC cycles. FLUSH_CYC defaults to 3.
- R7: A write whose bits 6:0 equal 0x02 is not queued. From the next cycle the queue is empty, `ovf_flag` is 0 and any flush hold is cancelled.
- R8: `head_data` shows the oldest held byte, or 0x00 when the queue is empty. A byte written to an empty queue appears there in the next cycle.
- R9: While `iss_valid` is high and `iss_ready` is low, `iss_op` and `iss_dma` stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host command write strobe |
| wr_data | input | 8 | Host command byte |
| role_i | input | 2 | Current controller role |
| head_data | output | 8 | Readback of the oldest queued byte |
| iss_valid | output | 1 | Legal command offered to the sequencer |
| iss_ready | input | 1 | Sequencer accepts the offered command |
| iss_op | output | 7 | Offered operation |
| iss_dma | output | 1 | Offered command requests DMA |
| illegal_o | output | 1 | Head command dropped as illegal for the role |
| ovf_flag | output | 1 | Sticky flag for a write dropped at a full queue |

## Verification
The hardest case to reach is a write to a full queue in the same cycle that the head leaves. The full queue only arises when the sequencer stalls and then releases at the right moment. A second hard case is a flush that reaches the head behind a stalled entry, with a role change in the middle of it. The stimulus first builds these situations with directed sequences that hold `iss_ready` low. It then runs a long random phase with a fixed seed, in which stalls, role changes and bursts of writes overlap freely. A cycle-level reference model in the bench supplies the expected value of every output in every cycle.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  typedef enum logic [1:0] {
    ROLE_DISC = 2'd0,
    ROLE_INIT = 2'd1,
    ROLE_TARG = 2'd2,
    ROLE_NONE = 2'd3
  } role_e;

  localparam logic [6:0] OP_FLUSH   = 7'h01;
  localparam logic [6:0] OP_RSTCHIP = 7'h02;
  localparam logic [6:0] OP_STOPDMA = 7'h04;

  // Mode-group check of one operation against the current role.
  function automatic logic cmd_legal(input logic [6:0] op, input logic [1:0] role);
    logic ok;
    unique case (op[6:4])
      3'b000:  ok = (op == OP_STOPDMA) ? (role == ROLE_TARG) : 1'b1;
      3'b100:  ok = (role == ROLE_DISC);
      3'b010:  ok = (role == ROLE_TARG);
      3'b001:  ok = (role == ROLE_INIT);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic is_flush(input logic [6:0] op);
    return op == OP_FLUSH;
  endfunction

  function automatic logic is_rstchip(input logic [6:0] op);
    return op == OP_RSTCHIP;
  endfunction
endpackage

// File: rtl/cmdq_store.sv
module cmdq_store #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  slot_q [DEPTH];
  logic [CW-1:0] count_q;
  logic          push_ok;
  logic          pop_ok;
  logic [CW-1:0] wr_idx;

  assign full    = (count_q == CW'(DEPTH));
  assign empty   = (count_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign wr_idx  = count_q - CW'(pop_ok);
  assign head    = slot_q[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] shift_in;
    if (i < DEPTH - 1) begin : g_mid
      assign shift_in = slot_q[i+1];
    end else begin : g_last
      assign shift_in = '0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             slot_q[i] <= '0;
      else if (push_ok && wr_idx == CW'(i))   slot_q[i] <= push_data;
      else if (pop_ok)                        slot_q[i] <= shift_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count_q <= '0;
    else if (clr) count_q <= '0;
    else          count_q <= count_q + CW'(push_ok) - CW'(pop_ok);
  end
endmodule

// File: rtl/cmdq_flush_timer.sv
module cmdq_flush_timer #(
  parameter int FLUSH_CYC = 3,
  localparam int TW       = $clog2(FLUSH_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic busy
);
  logic [TW-1:0] cnt_q;

  assign busy = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (start) cnt_q <= TW'(FLUSH_CYC);
    else if (busy)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/cmdq_gate.sv
module cmdq_gate
  import cmdq_pkg::*;
(
  input  logic [7:0] head,
  input  logic       present,
  input  logic       hold,
  input  logic [1:0] role,
  input  logic       ready,
  output logic       valid,
  output logic [6:0] op,
  output logic       dma,
  output logic       illegal,
  output logic       pop,
  output logic       flush_start
);
  logic live;
  logic ok;

  assign op          = head[6:0];
  assign dma         = head[7];
  assign live        = present && !hold;
  assign ok          = cmd_legal(op, role);
  assign valid       = live && ok;
  assign illegal     = live && !ok;
  assign pop         = (valid && ready) || illegal;
  assign flush_start = valid && ready && is_flush(op);
endmodule

// File: rtl/cmdq_top.sv
module cmdq_top
  import cmdq_pkg::*;
#(
  parameter int DEPTH     = 2,
  parameter int FLUSH_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] role_i,
  output logic [7:0] head_data,
  output logic       iss_valid,
  input  logic       iss_ready,
  output logic [6:0] iss_op,
  output logic       iss_dma,
  output logic       illegal_o,
  output logic       ovf_flag
);
  // Named internal events, also observed by the checker.
  logic       rc_wr;
  logic       push;
  logic       q_full;
  logic       q_empty;
  logic       fl_busy;
  logic       pop;
  logic       fl_start;
  logic [7:0] head;
  logic       ovf_q;

  assign rc_wr = wr_en && is_rstchip(wr_data[6:0]);
  assign push  = wr_en && !rc_wr;

  cmdq_store #(.W(8), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(rc_wr), .push(push), .push_data(wr_data),
    .pop(pop), .head(head), .full(q_full), .empty(q_empty)
  );

  cmdq_flush_timer #(.FLUSH_CYC(FLUSH_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(rc_wr), .start(fl_start), .busy(fl_busy)
  );

  cmdq_gate u_gate (
    .head(head), .present(!q_empty), .hold(fl_busy), .role(role_i),
    .ready(iss_ready), .valid(iss_valid), .op(iss_op), .dma(iss_dma),
    .illegal(illegal_o), .pop(pop), .flush_start(fl_start)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ovf_q <= 1'b0;
    else if (rc_wr)            ovf_q <= 1'b0;
    else if (push && q_full)   ovf_q <= 1'b1;
  end

  assign ovf_flag  = ovf_q;
  assign head_data = q_empty ? 8'h00 : head;
endmodule

// File: rtl/cmdq_checker.sv
module cmdq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       iss_valid,
  input logic       iss_ready,
  input logic [6:0] iss_op,
  input logic       iss_dma,
  input logic       illegal_o,
  input logic       ovf_flag,
  input logic [7:0] head_data,
  input logic       rc_wr,
  input logic       push,
  input logic       q_full,
  input logic       q_empty,
  input logic       fl_busy
);
  assert_overflow_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && q_full) |=> ovf_flag);

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !rc_wr) |=> ovf_flag);

  assert_illegal_no_offer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !iss_valid);

  assert_flush_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_busy |-> (!iss_valid && !illegal_o));

  assert_rstchip_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rc_wr |=> (q_empty && !ovf_flag && !fl_busy));

  assert_empty_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> (head_data == 8'h00 && !iss_valid && !illegal_o));

  assert_stall_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !rc_wr) |=> ($stable(iss_op) && $stable(iss_dma)));
endmodule

bind cmdq_top cmdq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
  .iss_dma(iss_dma), .illegal_o(illegal_o), .ovf_flag(ovf_flag),
  .head_data(head_data), .rc_wr(rc_wr), .push(push), .q_full(q_full),
  .q_empty(q_empty), .fl_busy(fl_busy)
);

// File: tb/cmdq_top_tb.sv
`timescale 1ns/1ps
module cmdq_top_tb;
  localparam int FL = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] role_i = 2'd0;
  logic       iss_ready = 1'b0;
  logic [7:0] head_data;
  logic       iss_valid;
  logic [6:0] iss_op;
  logic       iss_dma;
  logic       illegal_o;
  logic       ovf_flag;

  int ncmp = 0;
  int nerr = 0;
  bit done = 1'b0;

  // Reference model state.
  logic [7:0] mq [2];
  int  mcnt = 0;
  int  mfl = 0;
  bit  movf = 1'b0;
  bit  first = 1'b1;
  bit  after_rc = 1'b0;
  bit  prev_stall = 1'b0;

  always #2.5 clk = ~clk;

  cmdq_top #(.DEPTH(2), .FLUSH_CYC(FL)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .role_i(role_i), .head_data(head_data), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss_op(iss_op), .iss_dma(iss_dma),
    .illegal_o(illegal_o), .ovf_flag(ovf_flag)
  );

  // Legality table restated from R4.
  function automatic bit legal_ref(input logic [6:0] op, input logic [1:0] role);
    if (op[6:4] == 3'b000) return (op == 7'h04) ? (role == 2'd2) : 1'b1;
    if (op[6:4] == 3'b100) return role == 2'd0;
    if (op[6:4] == 3'b010) return role == 2'd2;
    if (op[6:4] == 3'b001) return role == 2'd1;
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    ncmp++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit wr, input logic [7:0] d, input bit rdy, input logic [1:0] role);
    logic [7:0] eh;
    bit blocked, lg, ev, ei, pop, fstart, rc, full;
    @(negedge clk);
    wr_en = wr; wr_data = d; iss_ready = rdy; role_i = role;
    #1;
    eh      = (mcnt > 0) ? mq[0] : 8'h00;
    blocked = (mfl != 0);
    lg      = legal_ref(eh[6:0], role);
    ev      = (mcnt > 0) && !blocked && lg;
    ei      = (mcnt > 0) && !blocked && !lg;
    if (first) begin
      chk("R1 valid", {7'd0, iss_valid}, 8'd0);
      chk("R1 illegal", {7'd0, illegal_o}, 8'd0);
      chk("R1 ovf", {7'd0, ovf_flag}, 8'd0);
      chk("R1 head", head_data, 8'h00);
      first = 1'b0;
    end else begin
      chk(blocked ? "R6 valid" : "R4 valid", {7'd0, iss_valid}, {7'd0, ev});
      chk(blocked ? "R6 illegal" : "R5 illegal", {7'd0, illegal_o}, {7'd0, ei});
      chk(after_rc ? "R7 ovf" : "R3 ovf", {7'd0, ovf_flag}, {7'd0, movf});
      chk(after_rc ? "R7 head" : "R8 head", head_data, eh);
      if (ev) chk(prev_stall ? "R9 op" : "R2 op", {iss_dma, iss_op}, eh);
    end
    // Advance the model past the coming clock edge.
    pop    = (ev && rdy) || ei;
    fstart = ev && rdy && (eh[6:0] == 7'h01);
    rc     = wr && (d[6:0] == 7'h02);
    prev_stall = ev && !rdy && !rc;
    after_rc   = rc;
    if (rc) begin
      mcnt = 0; movf = 1'b0; mfl = 0;
    end else begin
      mfl  = fstart ? FL : ((mfl > 0) ? mfl - 1 : 0);
      full = (mcnt == 2);
      if (pop) begin mq[0] = mq[1]; mcnt--; end
      if (wr) begin
        if (full) movf = 1'b1;
        else begin mq[mcnt] = d; mcnt++; end
      end
    end
  endtask

  function automatic logic [7:0] pick_cmd(input int unsigned r);
    logic [7:0] b;
    logic dm;
    dm = r[8];
    case (r % 9)
      0: b = {dm, 7'h01};
      1: b = {dm, 5'd0, r[10:9] | 2'b01};
      2: b = {dm, 7'h10 | 7'(r[11:9])};
      3: b = {dm, 7'h20 | 7'(r[12:9])};
      4: b = {dm, 7'h40 | 7'(r[11:9])};
      5: b = {dm, 7'h04};
      6: b = 8'(r >> 16);
      7: b = {dm, 7'h70 & 7'(r >> 9)};
      default: b = (r[15:12] == 4'd0) ? {dm, 7'h02} : {dm, 7'h00};
    endcase
    if (b[6:0] == 7'h02 && r % 9 != 8) b[1] = 1'b0;
    return b;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      nerr++; ncmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    logic [1:0] role;
    void'($urandom(32'd20250611));
    mq[0] = 8'h00; mq[1] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 8'h00, 0, 2'd1);                 // R1 reset state
    // R2/R8/R9: write pair with DMA repeat in initiator role, stall, then drain
    step(1, 8'h10, 0, 2'd1);
    step(1, 8'h90, 0, 2'd1);
    step(0, 8'h00, 0, 2'd1);
    // R3: full queue, write dropped even with a pop in the same cycle
    step(1, 8'h11, 1, 2'd1);
    step(1, 8'h12, 0, 2'd1);
    step(0, 8'h00, 1, 2'd1);
    step(0, 8'h00, 1, 2'd1);
    // R7: reset chip clears queue and overflow
    step(1, 8'h1a, 0, 2'd1);
    step(1, 8'h82, 0, 2'd1);
    step(0, 8'h00, 1, 2'd1);
    // R6: flush then a queued command held for FL cycles
    step(1, 8'h81, 0, 2'd0);
    step(1, 8'h41, 1, 2'd0);
    repeat (FL + 2) step(0, 8'h00, 1, 2'd0);
    // R4/R5: each group in each role
    for (int ro = 0; ro < 4; ro++) begin
      step(1, 8'h42, 1, 2'(ro));
      step(1, 8'h21, 1, 2'(ro));
      step(1, 8'h1b, 1, 2'(ro));
      step(1, 8'h04, 1, 2'(ro));
      step(1, 8'h60, 1, 2'(ro));
      step(1, 8'h03, 1, 2'(ro));
      repeat (3) step(0, 8'h00, 1, 2'(ro));
    end
    // Random phase
    role = 2'd1;
    for (int i = 0; i < 4000; i++) begin
      r = $urandom;
      if (r[31:28] == 4'd0) role = 2'($urandom % 4);
      step((r % 5) < 2, pick_cmd($urandom), (r[7:4] < 4'd11), role);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end
endmodule